// File: doc/BRIEF.md
# Processor Low-Power State Clock Controller

This block sequences a processor core and its on-die second-level cache through six power states. It watches a halt indication, a stop-grant request, a sleep request, a bus-clock-present flag, snoop request and completion strobes, an interrupt line and an internal clock-stable flag. From the current state it decides whether the cache clock runs, whether snoops and interrupts are accepted, and whether the board may stop the interrupt-controller clock.

The six states and their codes on `state_o` are Normal (0), AutoHALT (1), Stop-Grant (2), Halt/Grant Snoop (3), Sleep (4) and Deep Sleep (5). The named transitions are:
- HALT_ENTER: Normal to AutoHALT.
- GRANT_ENTER: Normal or AutoHALT to Stop-Grant.
- GRANT_RELEASE: Stop-Grant to Normal.
- IRQ_WAKE: AutoHALT to Normal.
- SNOOP_ENTER and SNOOP_RETURN: into and out of Halt/Grant Snoop.
- SLEEP_ENTER: Stop-Grant to Sleep.
- SLEEP_EXIT: Sleep to Stop-Grant.
- DEEP_ENTER: Sleep to Deep Sleep.
- DEEP_EXIT: Deep Sleep to Sleep.

The cache clock is stopped only in Deep Sleep. DEEP_EXIT waits until the bus clock is back and the internal clock has been reported stable for `STABLE_CNT` consecutive cycles, so the cache clock restarts only once the block is back in Sleep.

Top module: `lp_clk_ctrl`

## Requirements
- R1: While the synchronous active-high reset `rst` is sampled high, the next state is Normal (code 0), with `cache_clk_en_o`, `snoop_en_o` and `irq_en_o` high and `pic_clk_off_ok_o` low.
- R2: In Normal, `stpgnt_req_i` high moves to Stop-Grant (2); otherwise `halt_i` high moves to AutoHALT (1); otherwise the state holds.
- R3: In AutoHALT, `stpgnt_req_i` high moves to Stop-Grant; otherwise `snoop_req_i` high moves to Halt/Grant Snoop (3); otherwise `irq_i` high moves to Normal.
- R4: In Stop-Grant, `stpgnt_req_i` low moves to Normal; otherwise `sleep_req_i` high moves to Sleep (4); otherwise `snoop_req_i` high moves to Halt/Grant Snoop.
- R5: In Halt/Grant Snoop, the state holds until an edge samples `snoop_done_i` high. At that edge it returns to the state (AutoHALT or Stop-Grant) from which the snoop was entered.
- R6: In Sleep, `bclk_ok_i` low moves to Deep Sleep (5); otherwise `sleep_req_i` low moves to Stop-Grant.
- R7: Deep Sleep moves to Sleep only at the edge that completes `STABLE_CNT` consecutive edges in Deep Sleep with both `bclk_ok_i` and `clk_stable_i` high. Any edge with either input low restarts the count.
- R8: `cache_clk_en_o` is low in Deep Sleep and high in every other state.
- R9: `snoop_en_o` and `irq_en_o` are low in Sleep and Deep Sleep and high in the other four states. In those two states, `snoop_req_i` and `irq_i` do not change the state.
- R10: `pic_clk_off_ok_o` is high in Sleep and Deep Sleep and low in Normal, AutoHALT, Stop-Grant and Halt/Grant Snoop.
- R11: `state_o` never shows the unused codes 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_i | input | 1 | Halt instruction executed |
| stpgnt_req_i | input | 1 | Stop-grant request level |
| sleep_req_i | input | 1 | Sleep request level |
| bclk_ok_i | input | 1 | Bus clock present |
| snoop_req_i | input | 1 | Incoming bus snoop |
| snoop_done_i | input | 1 | Snoop service complete |
| irq_i | input | 1 | Interrupt pending |
| clk_stable_i | input | 1 | Internal clocking stable |
| state_o | output | 3 | Current state code |
| cache_clk_en_o | output | 1 | Cache clock enable |
| snoop_en_o | output | 1 | Snoops accepted |
| irq_en_o | output | 1 | Interrupts accepted |
| pic_clk_off_ok_o | output | 1 | Interrupt-controller clock may stop |

## Verification
The bench builds the block with `STABLE_CNT` = 3 rather than the default 4. With that value, random toggling of `bclk_ok_i` and `clk_stable_i` often completes a qualifying run, and it often breaks one. As a result, DEEP_EXIT is reached many times, and runs that restart partway through are exercised alongside them. Slowly changing level requests let the random walk reach Sleep and Deep Sleep. A mid-run reset checks R1 away from power-up.

// File: rtl/lp_pkg.sv
package lp_pkg;
    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_AHALT  = 3'd1,
        ST_GRANT  = 3'd2,
        ST_HGSNP  = 3'd3,
        ST_SLEEP  = 3'd4,
        ST_DEEP   = 3'd5
    } lp_state_e;
endpackage

// File: rtl/lp_wake.sv
module lp_wake #(
    parameter int STABLE_CNT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_deep,
    input  logic bclk_ok,
    input  logic clk_stable,
    output logic wake_ok
);
    localparam int CW = (STABLE_CNT > 1) ? $clog2(STABLE_CNT) : 1;
    localparam logic [CW-1:0] LAST = CW'(STABLE_CNT - 1);

    logic [CW-1:0] run_q;
    logic          good;

    assign good    = in_deep && bclk_ok && clk_stable;
    assign wake_ok = good && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !good) begin
            run_q <= '0;
        end else if (run_q != LAST) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/lp_fsm.sv
module lp_fsm
    import lp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      halt,
    input  logic      stpgnt_req,
    input  logic      sleep_req,
    input  logic      bclk_ok,
    input  logic      snoop_req,
    input  logic      snoop_done,
    input  logic      irq,
    input  logic      wake_ok,
    output lp_state_e state
);
    lp_state_e state_q, state_d;
    lp_state_e ret_q, ret_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_NORMAL;
            ret_q   <= ST_AHALT;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        unique case (state_q)
            ST_NORMAL: begin
                if (stpgnt_req)  state_d = ST_GRANT;   // GRANT_ENTER
                else if (halt)   state_d = ST_AHALT;   // HALT_ENTER
            end
            ST_AHALT: begin
                if (stpgnt_req) begin
                    state_d = ST_GRANT;                 // GRANT_ENTER
                end else if (snoop_req) begin
                    state_d = ST_HGSNP;                 // SNOOP_ENTER
                    ret_d   = ST_AHALT;
                end else if (irq) begin
                    state_d = ST_NORMAL;                // IRQ_WAKE
                end
            end
            ST_GRANT: begin
                if (!stpgnt_req) begin
                    state_d = ST_NORMAL;                // GRANT_RELEASE
                end else if (sleep_req) begin
                    state_d = ST_SLEEP;                 // SLEEP_ENTER
                end else if (snoop_req) begin
                    state_d = ST_HGSNP;                 // SNOOP_ENTER
                    ret_d   = ST_GRANT;
                end
            end
            ST_HGSNP: begin
                if (snoop_done) state_d = ret_q;        // SNOOP_RETURN
            end
            ST_SLEEP: begin
                if (!bclk_ok)        state_d = ST_DEEP;  // DEEP_ENTER
                else if (!sleep_req) state_d = ST_GRANT; // SLEEP_EXIT
            end
            ST_DEEP: begin
                if (wake_ok) state_d = ST_SLEEP;        // DEEP_EXIT
            end
            default: state_d = ST_NORMAL;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/lp_out.sv
module lp_out
    import lp_pkg::*;
(
    input  lp_state_e state,
    output logic      cache_en,
    output logic      snoop_en,
    output logic      irq_en,
    output logic      pic_off_ok
);
    always_comb begin
        cache_en   = 1'b1;
        snoop_en   = 1'b1;
        irq_en     = 1'b1;
        pic_off_ok = 1'b0;
        unique case (state)
            ST_NORMAL, ST_AHALT, ST_GRANT, ST_HGSNP: ;
            ST_SLEEP: begin
                snoop_en   = 1'b0;
                irq_en     = 1'b0;
                pic_off_ok = 1'b1;
            end
            ST_DEEP: begin
                cache_en   = 1'b0;
                snoop_en   = 1'b0;
                irq_en     = 1'b0;
                pic_off_ok = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lp_clk_ctrl.sv
module lp_clk_ctrl
    import lp_pkg::*;
#(
    parameter int STABLE_CNT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       halt_i,
    input  logic       stpgnt_req_i,
    input  logic       sleep_req_i,
    input  logic       bclk_ok_i,
    input  logic       snoop_req_i,
    input  logic       snoop_done_i,
    input  logic       irq_i,
    input  logic       clk_stable_i,
    output logic [2:0] state_o,
    output logic       cache_clk_en_o,
    output logic       snoop_en_o,
    output logic       irq_en_o,
    output logic       pic_clk_off_ok_o
);
    lp_state_e cur_st;
    logic      wake_ok;

    lp_wake #(.STABLE_CNT(STABLE_CNT)) u_wake (
        .clk        (clk),
        .rst        (rst),
        .in_deep    (cur_st == ST_DEEP),
        .bclk_ok    (bclk_ok_i),
        .clk_stable (clk_stable_i),
        .wake_ok    (wake_ok)
    );

    lp_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .halt       (halt_i),
        .stpgnt_req (stpgnt_req_i),
        .sleep_req  (sleep_req_i),
        .bclk_ok    (bclk_ok_i),
        .snoop_req  (snoop_req_i),
        .snoop_done (snoop_done_i),
        .irq        (irq_i),
        .wake_ok    (wake_ok),
        .state      (cur_st)
    );

    lp_out u_out (
        .state      (cur_st),
        .cache_en   (cache_clk_en_o),
        .snoop_en   (snoop_en_o),
        .irq_en     (irq_en_o),
        .pic_off_ok (pic_clk_off_ok_o)
    );

    assign state_o = cur_st;
endmodule

// File: rtl/lp_clk_ctrl_chk.sv
module lp_clk_ctrl_chk
    import lp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       stpgnt_req_i,
    input logic       bclk_ok_i,
    input logic       snoop_done_i,
    input logic       clk_stable_i,
    input logic [2:0] state_o,
    input logic       cache_clk_en_o,
    input logic       snoop_en_o,
    input logic       irq_en_o,
    input logic       pic_clk_off_ok_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state_o == ST_NORMAL && cache_clk_en_o && snoop_en_o && irq_en_o && !pic_clk_off_ok_o));

    // R3
    ahalt_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_AHALT && stpgnt_req_i) |=> state_o == ST_GRANT);

    // R5
    snoop_return_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_HGSNP && snoop_done_i) |=> (state_o == ST_AHALT || state_o == ST_GRANT));

    // R6
    deep_enter_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_SLEEP && !bclk_ok_i) |=> state_o == ST_DEEP);

    // R7
    deep_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DEEP && !(bclk_ok_i && clk_stable_i)) |=> state_o == ST_DEEP);

    // R8
    cache_gate_chk: assert property (@(posedge clk) disable iff (rst)
        cache_clk_en_o == (state_o != ST_DEEP));

    // R9
    sleep_deaf_chk: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_SLEEP || state_o == ST_DEEP) |-> (!snoop_en_o && !irq_en_o));

    // R10
    pic_stop_chk: assert property (@(posedge clk) disable iff (rst)
        pic_clk_off_ok_o == (state_o == ST_SLEEP || state_o == ST_DEEP));

    // R11
    legal_code_chk: assert property (@(posedge clk) disable iff (rst)
        state_o <= 3'd5);
endmodule

bind lp_clk_ctrl lp_clk_ctrl_chk u_chk (
    .clk              (clk),
    .rst              (rst),
    .stpgnt_req_i     (stpgnt_req_i),
    .bclk_ok_i        (bclk_ok_i),
    .snoop_done_i     (snoop_done_i),
    .clk_stable_i     (clk_stable_i),
    .state_o          (state_o),
    .cache_clk_en_o   (cache_clk_en_o),
    .snoop_en_o       (snoop_en_o),
    .irq_en_o         (irq_en_o),
    .pic_clk_off_ok_o (pic_clk_off_ok_o)
);

// File: tb/lp_clk_ctrl_tb.sv
`timescale 1ns/1ps
module lp_clk_ctrl_tb;
    localparam int STABLE = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic halt = 0, sg = 0, slp = 0, bok = 1, snp = 0, done = 0, irq = 0, stab = 0;
    logic [2:0] st;
    logic cache_en, snoop_en, irq_en, pic_ok;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    lp_clk_ctrl #(.STABLE_CNT(STABLE)) u_dut (
        .clk(clk), .rst(rst), .halt_i(halt), .stpgnt_req_i(sg), .sleep_req_i(slp),
        .bclk_ok_i(bok), .snoop_req_i(snp), .snoop_done_i(done), .irq_i(irq),
        .clk_stable_i(stab), .state_o(st), .cache_clk_en_o(cache_en),
        .snoop_en_o(snoop_en), .irq_en_o(irq_en), .pic_clk_off_ok_o(pic_ok)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference: 0 Normal, 1 AutoHALT, 2 Stop-Grant, 3 Snoop, 4 Sleep, 5 Deep
    int m_st = 0, m_ret = 1, m_run = 0;
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_ret = 1; m_run = 0;
        end else begin
            case (m_st)
                0: if (sg) m_st = 2; else if (halt) m_st = 1;
                1: if (sg) m_st = 2; else if (snp) begin m_ret = 1; m_st = 3; end
                   else if (irq) m_st = 0;
                2: if (!sg) m_st = 0; else if (slp) m_st = 4;
                   else if (snp) begin m_ret = 2; m_st = 3; end
                3: if (done) m_st = m_ret;
                4: begin m_run = 0; if (!bok) m_st = 5; else if (!slp) m_st = 2; end
                5: if (bok && stab) begin
                       m_run++;
                       if (m_run >= STABLE) begin m_st = 4; m_run = 0; end
                   end else m_run = 0;
                default: m_st = 0;
            endcase
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        bit sleepy;
        sleepy = (m_st == 4 || m_st == 5);
        chk("R2/R3/R4/R5/R6/R7/R11 state", int'(st), m_st);
        chk("R8 cache_clk_en", int'(cache_en), (m_st != 5) ? 1 : 0);
        chk("R9 snoop_en", int'(snoop_en), sleepy ? 0 : 1);
        chk("R9 irq_en", int'(irq_en), sleepy ? 0 : 1);
        chk("R10 pic_clk_off_ok", int'(pic_ok), sleepy ? 1 : 0);
    endtask

    function automatic bit flip(input int odds);
        return ($urandom % odds) == 0;
    endfunction

    initial begin
        repeat (2) @(negedge clk);
        compare_all();                      // R1 reset state
        rst = 0;
        // directed: Normal -> Stop-Grant -> Sleep -> Deep, broken stable run, wake
        @(negedge clk); compare_all(); sg = 1;
        @(negedge clk); compare_all(); slp = 1;
        @(negedge clk); compare_all(); bok = 0; irq = 1; snp = 1; // R9: ignored
        @(negedge clk); compare_all(); bok = 1; stab = 1;
        @(negedge clk); compare_all(); stab = 0;                  // R7 restart
        @(negedge clk); compare_all(); stab = 1;
        for (int i = 0; i < 5; i++) begin @(negedge clk); compare_all(); end
        irq = 0; snp = 0; slp = 0; sg = 0;
        for (int i = 0; i < 3; i++) begin @(negedge clk); compare_all(); end
        // random walk with slowly changing levels
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            compare_all();
            if (i == 3000) rst = 1; else rst = 0;
            if (flip(12)) sg = ~sg;
            if (flip(8))  slp = ~slp;
            if (flip(6))  bok = ~bok;
            stab = !flip(4);
            halt = flip(4);
            irq  = flip(6);
            snp  = flip(5);
            done = flip(3);
        end
        @(negedge clk); compare_all();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule